// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Target

This block is an I2C target that gives a host access to a small bank of 8-bit registers. SCL and SDA are sampled with the system clock through a synchronizer. START and STOP are found by watching SDA edges while SCL is high. The block answers one of two 7-bit addresses. A strap input selects which one. SDA is only ever pulled low, through an output-enable.

An 8-bit sub-address pointer selects the register. A write transaction loads the pointer from its first byte. The remaining bytes of the write are stored at the pointer, and the pointer advances by one after each byte. A read transaction starts at the current pointer. The pointer is kept across transactions. A read with no sub-address write before it therefore continues from the location after the last byte read or written.

The bank holds a read-only revision location and a run of read/write control locations. The control locations are presented in parallel as outputs.

Top module: `i2c_ptr_regbank`

## Requirements
- R1: The block acknowledges (pulls SDA low in the ninth bit) an address byte whose upper seven bits equal 1011100 when `addr_sel_i` is 0, or 1011101 when `addr_sel_i` is 1. Bit 0 of that byte selects the direction: 0 means write and 1 means read.
- R2: On an address mismatch the block never pulls SDA low until the next START or STOP. A read from the bus in that state sees 0xFF. The pointer keeps its value.
- R3: In a write, the block acknowledges every byte. The byte after the address loads the pointer. Each following byte is stored at the pointer, and the pointer then advances by one.
- R4: A write made only of the address and the sub-address, followed by STOP, changes no register.
- R5: A read returns bytes MSB-first, starting at the pointer. The pointer advances by one after each byte, so a read with no sub-address continues after the last location accessed.
- R6: After each read byte, an ACK from the host makes the block send the next byte. A NACK makes the block release SDA and stay silent until START or STOP. The pointer still advances past the NACKed byte.
- R7: After reset the pointer is 0x00, all control registers are 0x00, and SDA is released.
- R8: Offset 0x09 returns the parameter `REV_ID`. Writes to it are acknowledged and have no effect.
- R9: Offsets 0x0A and 0x0B are read/write and appear on `ctrl_o[7:0]` and `ctrl_o[15:8]`. Every other offset reads 0x00, and writes to it are acknowledged and ignored.
- R10: The pointer wraps from 0xFF to 0x00.
- R11: A START or STOP in the middle of a byte discards that byte. STOP returns the block to idle, and START returns it to address reception.
- R12: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| addr_sel_i | input | 1 | Strap: selects the LSB of the 7-bit target address |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| ctrl_o | output | 16 | Control registers: offset 0x0A in bits 7:0, offset 0x0B in bits 15:8 |

## Verification
The bench builds the block with `REV_ID` set to 0xA5 and every other parameter at its default. With a nonzero revision value, a read that walks the pointer up from reset, or around the 0xFF wrap, shows exactly where the pointer was: the one nonzero read-only byte lands at a known position in the stream. Left at its default of zero, that location could not be told apart from an unimplemented one. The two default control offsets keep the ignored-write cases (read-only, unimplemented) only one location away from real registers, so an off-by-one in address decode shows up directly on `ctrl_o`.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WRX,
    ST_WACK,
    ST_TX,
    ST_RACK,
    ST_RNEXT,
    ST_SKIP
  } eng_st_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_q  <= scl_sr[STAGES-1];
      sda_q  <= sda_sr[STAGES-1];
    end
  end

  assign scl_s    = scl_sr[STAGES-1];
  assign sda_s    = sda_sr[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_ptr_engine.sv
module i2c_ptr_engine
  import i2c_ptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [6:0]        own_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  eng_st_t           state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-2:0] tx;
  logic [BYTE_W-1:0] ptr;
  logic              rw;
  logic              sub_next;
  logic              ld_ptr;

  assign ptr_o  = ptr;
  assign ld_ptr = (state == ST_WACK) && scl_fall && sub_next && !start_ev && !stop_ev;

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      sub_next <= 1'b0;
      sda_oe   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (start_ev) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WRX: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (state == ST_WRX) begin
              sda_oe <= 1'b1;
              state  <= ST_WACK;
            end else if (sh[7:1] == own_addr) begin
              rw       <= sh[0];
              sub_next <= 1'b1;
              sda_oe   <= 1'b1;
              state    <= ST_AACK;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          if (rw) begin
            tx     <= rd_data[BYTE_W-2:0];
            sda_oe <= ~rd_data[BYTE_W-1];
            cnt    <= '0;
            state  <= ST_TX;
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_WRX;
          end
        end
        ST_WACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          state  <= ST_WRX;
          if (sub_next) begin
            ptr      <= sh;
            sub_next <= 1'b0;
          end else begin
            wr_en   <= 1'b1;
            wr_addr <= ptr;
            wr_data <= sh;
            ptr     <= ptr + 8'd1;
          end
        end
        ST_TX: if (scl_fall) begin
          if (cnt == 4'd7) begin
            sda_oe <= 1'b0;
            state  <= ST_RACK;
          end else begin
            cnt    <= cnt + 4'd1;
            sda_oe <= ~tx[BYTE_W-2];
            tx     <= {tx[BYTE_W-3:0], 1'b0};
          end
        end
        ST_RACK: if (scl_rise) begin
          ptr   <= ptr + 8'd1;
          state <= sda_s ? ST_SKIP : ST_RNEXT;
        end
        ST_RNEXT: if (scl_fall) begin
          tx     <= rd_data[BYTE_W-2:0];
          sda_oe <= ~rd_data[BYTE_W-1];
          cnt    <= '0;
          state  <= ST_TX;
        end
        default: ;
      endcase
    end
  end

  // R12: SDA drive moves only after an SCL-low sample, except on bus events
  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(start_ev) && !$past(stop_ev)) |-> !$past(scl_s));

  // R11: STOP goes idle and releases SDA; START re-arms address reception
  p_stop_idle_r11: assert property (@(posedge clk) disable iff (rst)
    stop_ev && !start_ev |=> (state == ST_IDLE) && !sda_oe);
  p_start_arm_r11: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (state == ST_ADDR) && (cnt == 4'd0));

  // R10 / R3: besides a sub-address load, the pointer moves only by +1 (mod 256)
  p_ptr_step_r10: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ptr) && !$past(ld_ptr)) |-> (ptr == $past(ptr) + 8'd1));

  // R2: silent while ignoring the bus
  p_skip_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !sda_oe);
endmodule

// File: rtl/i2c_ptr_regfile.sv
module i2c_ptr_regfile #(
  parameter int           DW        = 8,
  parameter int           AW        = 8,
  parameter int           NUM_CTRL  = 2,
  parameter logic [7:0]   CTRL_BASE = 8'h0A,
  parameter logic [7:0]   REV_OFS   = 8'h09,
  parameter logic [7:0]   REV_ID    = 8'h00
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [DW-1:0]          rd_data,
  output logic [NUM_CTRL*DW-1:0] ctrl_o
);
  localparam int CTRL_END = int'(CTRL_BASE) + NUM_CTRL;

  logic [DW-1:0] ctrl_q [NUM_CTRL];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (rst)
        ctrl_q[i] <= '0;
      else if (wr_en && wr_addr == AW'(int'(CTRL_BASE) + i))
        ctrl_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(REV_OFS))
      rd_data = DW'(REV_ID);
    for (int i = 0; i < NUM_CTRL; i++)
      if (rd_addr == AW'(int'(CTRL_BASE) + i))
        rd_data = ctrl_q[i];
  end

  for (genvar gi = 0; gi < NUM_CTRL; gi++) begin : g_out
    assign ctrl_o[gi*DW +: DW] = ctrl_q[gi];
  end

  // R8 / R9: a write outside the control window leaves every control register as it was
  p_ro_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (int'(wr_addr) < int'(CTRL_BASE) || int'(wr_addr) >= CTRL_END))
      |=> $stable(ctrl_o));
endmodule

// File: rtl/i2c_ptr_regbank.sv
module i2c_ptr_regbank
  import i2c_ptr_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_CTRL    = 2,
  parameter logic [5:0] ADDR_HI     = 6'b101110,
  parameter logic [7:0] CTRL_BASE   = 8'h0A,
  parameter logic [7:0] REV_OFS     = 8'h09,
  parameter logic [7:0] REV_ID      = 8'h00
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic                       addr_sel_i,
  output logic                       sda_oe_o,
  output logic [NUM_CTRL*BYTE_W-1:0] ctrl_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_addr, wr_data, ptr, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_ptr_engine u_eng (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .own_addr({ADDR_HI, addr_sel_i}), .rd_data(rd_data), .ptr_o(ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe_o)
  );

  i2c_ptr_regfile #(
    .DW(BYTE_W), .AW(BYTE_W), .NUM_CTRL(NUM_CTRL),
    .CTRL_BASE(CTRL_BASE), .REV_OFS(REV_OFS), .REV_ID(REV_ID)
  ) u_rf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data), .ctrl_o(ctrl_o)
  );
endmodule

// File: tb/tb_i2c_ptr_regbank.sv
module tb_i2c_ptr_regbank;
  localparam logic [7:0] REV = 8'hA5;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_oe;
  logic [15:0] ctrl;
  logic sda_bus;

  int vectors = 0, miscompares = 0, r12_viol = 0;
  logic [7:0] m_ctrl [2];
  logic [7:0] m_ptr;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_ptr_regbank #(.REV_ID(REV)) dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(strap), .sda_oe_o(sda_oe), .ctrl_o(ctrl)
  );

  // R12 monitor: the drive must never move while SCL is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && sda_oe != oe_prev && scl_m) r12_viol++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == 8'h09) return REV;
    if (a == 8'h0A) return m_ctrl[0];
    if (a == 8'h0B) return m_ctrl[1];
    return 8'h00;
  endfunction

  function automatic logic [6:0] own7();
    return {6'b101110, strap};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); d[i] = sda_bus; wq(); scl_m = 1'b0;
    end
    wq(); sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  // write: address, optional sub-address, n data bytes
  task automatic do_write(input logic [6:0] a7, input bit has_sub,
                          input logic [7:0] sub, input int n, input logic [7:0] first);
    logic ack, hit;
    logic [7:0] d;
    hit = (a7 == own7());
    bus_start();
    send_byte({a7, 1'b0}, ack);
    check(hit ? "R1 address ack" : "R2 mismatch nack", {15'd0, ack}, {15'd0, hit});
    if (hit) begin
      if (has_sub) begin
        send_byte(sub, ack);
        check("R3 sub-address ack", {15'd0, ack}, 16'd1);
        m_ptr = sub;
      end
      for (int k = 0; k < n; k++) begin
        d = (k == 0) ? first : 8'($urandom);
        send_byte(d, ack);
        check("R3/R9 data ack", {15'd0, ack}, 16'd1);
        if (m_ptr == 8'h0A) m_ctrl[0] = d;
        if (m_ptr == 8'h0B) m_ctrl[1] = d;
        m_ptr = m_ptr + 8'd1;
      end
    end
    bus_stop();
    wq();
    check("R3/R4/R8/R9 control outputs", ctrl, {m_ctrl[1], m_ctrl[0]});
  endtask

  task automatic read_body(input int n);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      check("R5/R10 read data", {8'd0, d}, {8'd0, exp_rd(m_ptr)});
      m_ptr = m_ptr + 8'd1;
    end
    wq();
    check("R6 SDA released after NACK", {15'd0, sda_oe}, 16'd0);
  endtask

  task automatic do_read(input logic [6:0] a7, input int n);
    logic ack, hit;
    logic [7:0] d;
    hit = (a7 == own7());
    bus_start();
    send_byte({a7, 1'b1}, ack);
    check(hit ? "R1 read address ack" : "R2 mismatch nack", {15'd0, ack}, {15'd0, hit});
    if (hit) read_body(n);
    else begin
      recv_byte(1'b0, d);
      check("R2 silent bus reads FF", {8'd0, d}, 16'h00FF);
    end
    bus_stop();
  endtask

  // sub-address write, then repeated START into a read
  task automatic do_sub_read(input logic [7:0] sub, input int n);
    logic ack;
    bus_start();
    send_byte({own7(), 1'b0}, ack);
    send_byte(sub, ack);
    check("R3 sub-address ack", {15'd0, ack}, 16'd1);
    m_ptr = sub;
    bus_start();
    send_byte({own7(), 1'b1}, ack);
    check("R1 repeated start ack", {15'd0, ack}, 16'd1);
    read_body(n);
    bus_stop();
  endtask

  initial begin
    logic ack;
    m_ctrl[0] = 8'h00; m_ctrl[1] = 8'h00; m_ptr = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    wq();
    check("R7 reset SDA released", {15'd0, sda_oe}, 16'd0);
    check("R7 reset control outputs", ctrl, 16'h0000);

    // R7: pointer starts at 0 -> 10th byte is the revision
    do_read(own7(), 10);
    // R3 write, R9 outputs
    do_write(own7(), 1'b1, 8'h0A, 2, 8'h3C);
    // R4 pointer-only write, then read from it (R5)
    do_write(own7(), 1'b1, 8'h09, 0, 8'h00);
    do_read(own7(), 3);
    do_read(own7(), 1);  // continues at 0x0C (R5, R9)
    // R8 read-only write ignored
    do_write(own7(), 1'b1, 8'h09, 1, 8'hFF);
    do_sub_read(8'h09, 1);
    // R10 wrap: FF,00..09
    do_sub_read(8'hFF, 11);
    do_write(own7(), 1'b1, 8'hFE, 3, 8'h77);
    do_read(own7(), 11);
    // R2 other strap address
    strap = 1'b1;
    do_write(7'b1011100, 1'b1, 8'h0A, 1, 8'h11);
    do_read(own7(), 2);
    do_read(7'b1011100, 1);
    do_read(own7(), 1);
    // R11 abort by STOP mid-byte
    do_write(own7(), 1'b1, 8'h0B, 1, 8'h5E);
    bus_start();
    send_byte({own7(), 1'b0}, ack);
    send_byte(8'h0A, ack);
    m_ptr = 8'h0A;
    send_bits(8'hFF, 4);
    bus_stop();
    wq();
    check("R11 STOP mid-byte discards", ctrl, {m_ctrl[1], m_ctrl[0]});
    // R11 abort by repeated START mid-byte
    bus_start();
    send_byte({own7(), 1'b0}, ack);
    send_bits(8'h0B, 5);
    bus_start();
    send_byte({own7(), 1'b1}, ack);
    check("R11 START mid-byte re-arms address", {15'd0, ack}, 16'd1);
    read_body(2);
    bus_stop();

    // random mix
    for (int t = 0; t < 40; t++) begin
      int kind;
      logic [7:0] sub;
      kind = $urandom_range(0, 4);
      strap = 1'($urandom);
      case ($urandom_range(0, 3))
        0: sub = 8'h09;
        1: sub = 8'h0A;
        2: sub = 8'hFE;
        default: sub = 8'($urandom);
      endcase
      case (kind)
        0: do_write(own7(), 1'b1, sub, $urandom_range(1, 3), 8'($urandom));
        1: do_write(own7(), 1'b1, sub, 0, 8'h00);
        2: do_read(own7(), $urandom_range(1, 4));
        3: do_sub_read(sub, $urandom_range(1, 3));
        default: do_read({6'b101110, ~strap}, 1);
      endcase
    end

    check("R12 SDA drive changes while SCL high", r12_viol[15:0], 16'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (190000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule